// File: doc/BRIEF.md
# Mode-Switchable Redundant Multiply-Accumulate Group

This block holds three identical multiply-accumulate processing elements whose redundancy level is chosen while the chip runs. In performance mode each element takes its own operand lane and keeps its own running sum, giving three independent results. In duplicated mode elements 0 and 1 both work on the lane-0 operands and their sums are compared, while element 2 stays independent on lane 2. In triplicated mode all three elements work on the lane-0 operands, and a bitwise 2-of-3 voter produces the output and names the one element that disagreed.

A scheduler sets the mode between layers, so each layer can trade throughput for reliability. A mode change takes effect only in an idle cycle with nothing in the pipeline, and it clears every running sum. Every operation gives a result exactly two cycles after it is accepted, whatever the mode.

Top module: `redundant_mac_group`

## Requirements
- R1: After reset all result lanes read 0, `out_valid_o`, `cmp_err_o` and `tmr_lane_o` are 0, and the active mode is performance.
- R2: An operation accepted with `in_valid_i` high at a rising edge gives `out_valid_o` high for exactly one cycle, after the second rising edge that follows it.
- R3: In performance mode (code 2'b00) each lane k adds `a_k*b_k` (unsigned) to its own sum, and result lane k shows that sum. The sum wraps modulo 2^ACC_W.
- R4: In duplicated mode (code 2'b01) elements 0 and 1 both take the lane-0 operands and element 2 takes the lane-2 operands. The lane-1 operands have no effect on any result.
- R5: In duplicated mode `cmp_err_o` is high in the cycle `out_valid_o` is high exactly when the sums of elements 0 and 1 differ. Result lanes 0, 1 and 2 show the sums of elements 0, 1 and 2.
- R6: In triplicated mode (code 2'b10) all three elements take the lane-0 operands, and all three result lanes show the bitwise majority of the three sums.
- R7: In triplicated mode `tmr_lane_o` is 0 when all three sums agree. It is 1, 2 or 3 when only element 0, 1 or 2 respectively differs from the other two. It is non-zero only while `out_valid_o` is high.
- R8: In triplicated mode, if no two sums agree, `cmp_err_o` is high, `tmr_lane_o` is 0, and the result lanes still show the bitwise majority.
- R9: Code 2'b11 behaves as triplicated mode. A switch between 2'b10 and 2'b11 is not a mode change and does not clear the sums.
- R10: A mode change is taken only at an edge where `in_valid_i` is low and no operation is in the pipeline. An operation issued while `mode_i` shows a new code runs in the previous mode.
- R11: A mode change that is taken clears all three sums, so the next operation in the new mode starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Requested redundancy mode: 00 performance, 01 duplicated, 10/11 triplicated |
| in_valid_i | input | 1 | Operands on all lanes are valid this cycle |
| a_i | input | 3*DATA_W | Multiplicand per lane, lane k at bits [k*DATA_W +: DATA_W] |
| b_i | input | 3*DATA_W | Multiplier per lane, same packing as a_i |
| out_valid_o | output | 1 | Result lanes and flags belong to an operation |
| res_o | output | 3*ACC_W | Result per lane, lane k at bits [k*ACC_W +: ACC_W] |
| cmp_err_o | output | 1 | Duplicated mismatch, or triplicated vote with no majority |
| tmr_lane_o | output | 2 | Triplicated: 0 none, 1/2/3 = element 0/1/2 outvoted |

## Verification
In performance mode the bench gives each lane distinct operands and repeats the operation, which tells steering errors apart from accumulation errors. In duplicated mode the lane-1 operands differ from lane 0 on purpose, so any leak of them shows in result lane 1. The bench then forces one element's sum to a wrong value to raise the comparator flag. In triplicated mode the bench forces one element wrong at a time, and then all three apart, which tells a correct vote from a correct lane code and from the no-majority case. Mode codes are also changed while an operation is issued, and between 2'b10 and 2'b11, to show when sums clear and when they do not.

// File: rtl/redmac_pkg.sv
// Package: shared mode type and raw-code decode for the redundant MAC group.
// Assumes the two-bit mode code; the unused code maps onto triplicated mode.
package redmac_pkg;

    localparam int NLANE = 3;

    typedef enum logic [1:0] {
        MODE_PERF   = 2'b00,
        MODE_DUAL   = 2'b01,
        MODE_TRIPLE = 2'b10
    } red_mode_e;

    // Map a raw request code onto a legal operating mode
    function automatic red_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'b00:   return MODE_PERF;
            2'b01:   return MODE_DUAL;
            default: return MODE_TRIPLE;
        endcase
    endfunction

endpackage

// File: rtl/redmac_steer.sv
// Operand steering: picks which operand lane feeds each element in the
// active mode. Purely combinational; assumes mode is stable for the operation.
module redmac_steer
    import redmac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  red_mode_e                 mode_i,
    input  logic [NLANE*DATA_W-1:0]   a_i,
    input  logic [NLANE*DATA_W-1:0]   b_i,
    output logic [NLANE*DATA_W-1:0]   a_o,
    output logic [NLANE*DATA_W-1:0]   b_o
);

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic use_lane0;

        // Decide whether element k shares the lane-0 operands
        always_comb begin
            case (mode_i)
                MODE_DUAL:   use_lane0 = (k == 1);
                MODE_TRIPLE: use_lane0 = (k != 0);
                default:     use_lane0 = 1'b0;
            endcase
        end

        // Route the chosen operand pair to element k
        always_comb begin
            if (use_lane0) begin
                a_o[k*DATA_W +: DATA_W] = a_i[0 +: DATA_W];
                b_o[k*DATA_W +: DATA_W] = b_i[0 +: DATA_W];
            end else begin
                a_o[k*DATA_W +: DATA_W] = a_i[k*DATA_W +: DATA_W];
                b_o[k*DATA_W +: DATA_W] = b_i[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/redmac_pe.sv
// One multiply-accumulate element: unsigned product added into a wrapping
// sum register. Assumes clear and enable are never high together.
module redmac_pe #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [ACC_W-1:0]  acc_o
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc_q;

    // Form the full-width product of the two operands
    always_comb prod = PROD_W'(a_i) * PROD_W'(b_i);

    // Hold, clear or accumulate the running sum
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= acc_q + ACC_W'(prod);
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/redmac_vote.sv
// Result combiner: passes sums through, compares a pair, or votes 2-of-3
// bitwise and locates the outvoted element. Purely combinational.
module redmac_vote
    import redmac_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  red_mode_e                mode_i,
    input  logic [NLANE*ACC_W-1:0]   acc_i,
    output logic [NLANE*ACC_W-1:0]   res_o,
    output logic                     err_o,
    output logic [1:0]               lane_o
);

    logic [ACC_W-1:0] s0, s1, s2, maj;
    logic             eq01, eq02, eq12;

    // Split the packed sums and compare every pair
    always_comb begin
        s0   = acc_i[0*ACC_W +: ACC_W];
        s1   = acc_i[1*ACC_W +: ACC_W];
        s2   = acc_i[2*ACC_W +: ACC_W];
        eq01 = (s0 == s1);
        eq02 = (s0 == s2);
        eq12 = (s1 == s2);
        maj  = (s0 & s1) | (s0 & s2) | (s1 & s2);
    end

    // Select outputs and flags for the active mode
    always_comb begin
        res_o  = acc_i;
        err_o  = 1'b0;
        lane_o = 2'd0;
        case (mode_i)
            MODE_DUAL: begin
                err_o = !eq01;
            end
            MODE_TRIPLE: begin
                res_o = {maj, maj, maj};
                if (eq01 && eq12) begin
                    lane_o = 2'd0;
                end else if (eq12) begin
                    lane_o = 2'd1;
                end else if (eq02) begin
                    lane_o = 2'd2;
                end else if (eq01) begin
                    lane_o = 2'd3;
                end else begin
                    err_o = 1'b1;
                end
            end
            default: begin
                res_o = acc_i;
            end
        endcase
    end

endmodule

// File: rtl/redundant_mac_group.sv
// Top of the redundant MAC group: holds the active mode, steers operands,
// runs three elements and registers the combined result two cycles after
// an operation is accepted. Assumes operands are valid only with in_valid_i.
module redundant_mac_group
    import redmac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic                     in_valid_i,
    input  logic [NLANE*DATA_W-1:0]  a_i,
    input  logic [NLANE*DATA_W-1:0]  b_i,
    output logic                     out_valid_o,
    output logic [NLANE*ACC_W-1:0]   res_o,
    output logic                     cmp_err_o,
    output logic [1:0]               tmr_lane_o
);

    red_mode_e               mode_q;
    red_mode_e               mode_req;
    logic                    mode_take;
    logic                    busy_q;
    logic [NLANE*DATA_W-1:0] a_s, b_s;
    logic [NLANE*ACC_W-1:0]  acc_all;
    logic [NLANE*ACC_W-1:0]  res_c;
    logic                    err_c;
    logic [1:0]              lane_c;

    // Decide whether a requested mode change can be taken this edge
    always_comb begin
        mode_req  = decode_mode(mode_i);
        mode_take = (mode_req != mode_q) && !in_valid_i && !busy_q;
    end

    // Track the active mode and whether an operation sits in the sums
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PERF;
            busy_q <= 1'b0;
        end else begin
            busy_q <= in_valid_i;
            if (mode_take) begin
                mode_q <= mode_req;
            end
        end
    end

    redmac_steer #(.DATA_W(DATA_W)) u_steer (
        .mode_i (mode_q),
        .a_i    (a_i),
        .b_i    (b_i),
        .a_o    (a_s),
        .b_o    (b_s)
    );

    for (genvar k = 0; k < NLANE; k++) begin : g_pe
        redmac_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (mode_take),
            .en_i  (in_valid_i),
            .a_i   (a_s[k*DATA_W +: DATA_W]),
            .b_i   (b_s[k*DATA_W +: DATA_W]),
            .acc_o (acc_all[k*ACC_W +: ACC_W])
        );
    end

    redmac_vote #(.ACC_W(ACC_W)) u_vote (
        .mode_i (mode_q),
        .acc_i  (acc_all),
        .res_o  (res_c),
        .err_o  (err_c),
        .lane_o (lane_c)
    );

    // Register the combined result and one-cycle flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            res_o       <= '0;
            cmp_err_o   <= 1'b0;
            tmr_lane_o  <= 2'd0;
        end else begin
            out_valid_o <= busy_q;
            cmp_err_o   <= busy_q && err_c;
            tmr_lane_o  <= busy_q ? lane_c : 2'd0;
            if (busy_q) begin
                res_o <= res_c;
            end
        end
    end

endmodule

// File: rtl/redmac_chk.sv
// Checker for the redundant MAC group, bound to the top module.
// Assumes reset is held low from time zero.
module redmac_chk #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             out_valid_o,
    input  logic             cmp_err_o,
    input  logic [1:0]       tmr_lane_o,
    input  logic [1:0]       mode_q,
    input  logic [3*ACC_W-1:0] acc_all
);

    // R2
    lat_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid_i, 2) |-> out_valid_o);

    // R2
    lat_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i, 2));

    // R5
    err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err_o |-> out_valid_o);

    // R7
    lane_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_lane_o != 2'd0) |-> (out_valid_o && !cmp_err_o));

    // R10
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> ($past(!in_valid_i) && !out_valid_o));

    // R11
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> (acc_all == '0));

endmodule

bind redundant_mac_group redmac_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .cmp_err_o   (cmp_err_o),
    .tmr_lane_o  (tmr_lane_o),
    .mode_q      (mode_q),
    .acc_all     (acc_all)
);

// File: tb/sim_redundant_mac_group.sv
module sim_redundant_mac_group;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int ACC_W      = 24;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            mode_i = 2'b00;
    logic                  in_valid_i = 1'b0;
    logic [3*DATA_W-1:0]   a_i = '0;
    logic [3*DATA_W-1:0]   b_i = '0;
    logic                  out_valid_o;
    logic [3*ACC_W-1:0]    res_o;
    logic                  cmp_err_o;
    logic [1:0]            tmr_lane_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redundant_mac_group #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u0 (
        .clk, .rst_n, .mode_i, .in_valid_i, .a_i, .b_i,
        .out_valid_o, .res_o, .cmp_err_o, .tmr_lane_o
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_res(input string req, input longint e0,
                             input longint e1, input longint e2);
        check(req, "lane0", res_o[0*ACC_W +: ACC_W], e0);
        check(req, "lane1", res_o[1*ACC_W +: ACC_W], e1);
        check(req, "lane2", res_o[2*ACC_W +: ACC_W], e2);
    endtask

    // Issue one operation; returns at the negedge where the result is visible
    task automatic run_op(input logic [7:0] a0, input logic [7:0] b0,
                          input logic [7:0] a1, input logic [7:0] b1,
                          input logic [7:0] a2, input logic [7:0] b2);
        a_i = {a2, a1, a0};
        b_i = {b2, b1, b0};
        in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R2", "valid early", out_valid_o, 0);
        @(negedge clk);
        check("R2", "valid on time", out_valid_o, 1);
    endtask

    task automatic after_op();
        @(negedge clk);
        check("R2", "valid single cycle", out_valid_o, 0);
        check("R7", "lane code idle", tmr_lane_o, 0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_i = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "valid", out_valid_o, 0);
        check("R1", "err", cmp_err_o, 0);
        check("R1", "lane", tmr_lane_o, 0);
        check_res("R1", 0, 0, 0);
    endtask

    task automatic t_perf();
        run_op(3, 4, 5, 6, 7, 8);
        check_res("R3", 12, 30, 56);
        check("R3", "err", cmp_err_o, 0);
        after_op();
        run_op(2, 2, 1, 1, 0, 9);
        check_res("R3", 16, 31, 56);
        after_op();
        run_op(255, 255, 255, 255, 0, 0);
        check_res("R3", 16 + 65025, 31 + 65025, 56);
        after_op();
    endtask

    task automatic t_dual();
        set_mode(2'b01);
        run_op(10, 10, 99, 99, 2, 3);
        check_res("R4 R11", 100, 100, 6);
        check("R5", "no mismatch", cmp_err_o, 0);
        after_op();
        force u0.g_pe[1].u_pe.acc_q = 24'd7;
        run_op(1, 1, 50, 50, 1, 1);
        check_res("R5", 101, 7, 7);
        check("R5", "mismatch", cmp_err_o, 1);
        release u0.g_pe[1].u_pe.acc_q;
        @(negedge clk);
        check("R5", "flag one cycle", cmp_err_o, 0);
    endtask

    task automatic t_triple();
        set_mode(2'b10);
        run_op(5, 6, 1, 1, 2, 2);
        check_res("R6 R11", 30, 30, 30);
        check("R7", "agree", tmr_lane_o, 0);
        check("R8", "no err", cmp_err_o, 0);
        after_op();
        force u0.g_pe[2].u_pe.acc_q = 24'h001234;
        run_op(1, 2, 9, 9, 9, 9);
        check_res("R6", 32, 32, 32);
        check("R7", "lane2 out", tmr_lane_o, 3);
        release u0.g_pe[2].u_pe.acc_q;
        after_op();
        force u0.g_pe[0].u_pe.acc_q = 24'd40;
        force u0.g_pe[1].u_pe.acc_q = 24'd34;
        force u0.g_pe[2].u_pe.acc_q = 24'd34;
        run_op(1, 1, 0, 0, 0, 0);
        check_res("R6", 34, 34, 34);
        check("R7", "lane0 out", tmr_lane_o, 1);
        after_op();
        force u0.g_pe[0].u_pe.acc_q = 24'd1;
        force u0.g_pe[1].u_pe.acc_q = 24'd3;
        force u0.g_pe[2].u_pe.acc_q = 24'd6;
        run_op(1, 1, 0, 0, 0, 0);
        check_res("R8", 3, 3, 3);
        check("R8", "no majority err", cmp_err_o, 1);
        check("R8", "lane code", tmr_lane_o, 0);
        release u0.g_pe[0].u_pe.acc_q;
        release u0.g_pe[1].u_pe.acc_q;
        release u0.g_pe[2].u_pe.acc_q;
        after_op();
        set_mode(2'b00);
        set_mode(2'b10);
    endtask

    task automatic t_illegal();
        run_op(2, 2, 7, 7, 7, 7);
        check_res("R9", 4, 4, 4);
        after_op();
        set_mode(2'b11);
        run_op(1, 1, 8, 8, 8, 8);
        check_res("R9", 5, 5, 5);
        check("R9", "lane", tmr_lane_o, 0);
        after_op();
    endtask

    task automatic t_change();
        mode_i = 2'b00;
        run_op(1, 1, 9, 9, 9, 9);
        check_res("R10", 6, 6, 6);
        after_op();
        run_op(2, 3, 4, 5, 6, 7);
        check_res("R10 R11", 6, 20, 42);
        after_op();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_perf();
        t_dual();
        t_triple();
        t_illegal();
        t_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule